// File: doc/BRIEF.md
# Predicated Outer-Product Accumulate Engine

This block keeps a square tile of half-precision accumulators in registers and adds into it the outer product of a column vector A and a row vector B. A single start strobe captures both vectors, both predicate masks and a subtract flag. The engine then walks the tile in row-major order and performs one fused multiply-add per cycle. A tile element is changed only when its row predicate and its column predicate are both active. In subtract mode the row operand A[row] is negated first, which turns the update into multiply-subtract.

The tile side is DIM by DIM elements, with DIM=4 by default. Each vector carries DIM 16-bit lanes and each predicate carries two bits per lane. Software-visible state is reached through a registered read port. The arithmetic is a reduced FP16 fused multiply-add: round to nearest with ties to even, subnormals flushed, and one canonical NaN.

Top module: `opa_engine`

## Requirements
- R1: After reset every tile element reads 16'h0000, and busy and done are low.
- R2: A start seen while idle raises busy on the next cycle. Busy stays high for exactly DIM*DIM cycles. Done is high for the single cycle after the last element write, and in that cycle busy is already low, so a new start is accepted.
- R3: Element (r,c) sits at read address r*DIM+c and is updated from A lane r (vec_a bits 16r+15..16r) and B lane c (vec_b bits 16c+15..16c). The walk is row-major, one element per cycle.
- R4: Lane i of A is active when pred_a bit 2i is set, and lane i of B is active when pred_b bit 2i is set. Odd predicate bits are ignored. An element whose row lane or column lane is inactive keeps its value.
- R5: An active element becomes old + A[r]*B[c], computed with one rounding, to nearest with ties to even.
- R6: When sub_mode is 1 at start, A[r] is negated before the multiply-add. When it is 0, A[r] is used unchanged.
- R7: A start that arrives while busy is ignored. It does not disturb the operation in flight and does not queue a second one.
- R8: An input with exponent field 0 counts as a signed zero. A result whose exact magnitude is below 2^-14 before rounding becomes a zero carrying the result's sign.
- R9: Any NaN input, infinity times zero, or infinity plus an opposite infinity gives 16'h7E00.
- R10: A rounded result with exponent 31 or more gives infinity with the result's sign.
- R11: An exact zero sum of nonzero terms gives +0. If the product and the old value are both zero, the result is -0 only when both are negative.
- R12: rd_data shows the element at rd_addr one cycle after the address is presented. If that element is written on the same edge, rd_data shows the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an accumulate pass when idle |
| sub_mode | input | 1 | Negate A lanes (multiply-subtract) |
| vec_a | input | DIM*16 | Column operand lanes |
| vec_b | input | DIM*16 | Row operand lanes |
| pred_a | input | DIM*2 | Predicate for A lanes |
| pred_b | input | DIM*2 | Predicate for B lanes |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_addr | input | log2(DIM*DIM) | Tile read address |
| rd_data | output | 16 | Registered tile read data |

## Verification
The completion pulse and the acceptance of a new start can occur in the same cycle. The bench provokes this by raising start exactly in the cycle where done is high, several times back to back, while the previous pass's results are still only in the tile. It then judges that busy rises in the next cycle with no idle gap, and that every element equals the reference model applied the same number of times in sequence. Starts raised in the middle of a pass are also checked: they must leave both the cycle count and the final tile unchanged.

// File: rtl/opa_pkg.sv
package opa_pkg;
  localparam int EW    = 16;
  localparam int EXPW  = 5;
  localparam int FRACW = 10;
  localparam logic [EW-1:0] QNAN = 16'h7E00;

  typedef struct packed {
    logic             sgn;
    logic [EXPW-1:0]  ex;
    logic [FRACW-1:0] fr;
  } fp16_t;
endpackage

// File: rtl/opa_fma16.sv
module opa_fma16
  import opa_pkg::*;
(
  input  logic [EW-1:0] a_i,
  input  logic [EW-1:0] b_i,
  input  logic [EW-1:0] c_i,
  output logic [EW-1:0] r_o
);
  fp16_t a, b, c;
  assign a = fp16_t'(a_i);
  assign b = fp16_t'(b_i);
  assign c = fp16_t'(c_i);

  logic a_nan, b_nan, c_nan, a_inf, b_inf, c_inf, a_zero, b_zero, c_zero, sp;
  assign a_nan  = (&a.ex) && (|a.fr);
  assign b_nan  = (&b.ex) && (|b.fr);
  assign c_nan  = (&c.ex) && (|c.fr);
  assign a_inf  = (&a.ex) && !(|a.fr);
  assign b_inf  = (&b.ex) && !(|b.fr);
  assign c_inf  = (&c.ex) && !(|c.fr);
  assign a_zero = ~|a.ex;
  assign b_zero = ~|b.ex;
  assign c_zero = ~|c.ex;
  assign sp     = a.sgn ^ b.sgn;

  logic [21:0] prod;
  assign prod = {1'b1, a.fr} * {1'b1, b.fr};

  // both terms as X * 2^(e-38) in a 26-bit frame with three guard bits
  logic [25:0] xp, xc;
  logic signed [9:0] ep, ec;
  assign xp = {1'b0, prod, 3'b000};
  assign xc = c_zero ? 26'd0 : {2'b00, 1'b1, c.fr, 13'd0};
  assign ep = $signed({5'd0, a.ex}) + $signed({5'd0, b.ex}) - 10'sd15;
  assign ec = c_zero ? -10'sd64 : $signed({5'd0, c.ex});

  logic        swap, sbig, ssml, rsgn, rnd;
  logic [25:0] big, sml, sml_al;
  logic signed [9:0] ebig, esml, d, er, er_r;
  logic [4:0]  dsh, lz;
  logic [26:0] s, sn;
  logic [11:0] mant_r;

  always_comb begin
    swap = ec > ep;
    big  = swap ? xc : xp;
    sml  = swap ? xp : xc;
    ebig = swap ? ec : ep;
    esml = swap ? ep : ec;
    sbig = swap ? c.sgn : sp;
    ssml = swap ? sp : c.sgn;
    d    = ebig - esml;
    dsh  = d[4:0];
    if (d > 10'sd26) sml_al = {25'd0, |sml};
    else             sml_al = (sml >> dsh) | {25'd0, |(sml & ~({26{1'b1}} << dsh))};
    if (sbig == ssml) begin
      s    = {1'b0, big} + {1'b0, sml_al};
      rsgn = sbig;
    end else if (big >= sml_al) begin
      s    = {1'b0, big} - {1'b0, sml_al};
      rsgn = sbig;
    end else begin
      s    = {1'b0, sml_al} - {1'b0, big};
      rsgn = ssml;
    end
    lz = 5'd0;
    for (int i = 0; i < 27; i++) if (s[i]) lz = 5'(i);
    sn     = s << (5'd26 - lz);
    er     = $signed({5'd0, lz}) + ebig - 10'sd23;
    rnd    = sn[15] & ((|sn[14:0]) | sn[16]);
    mant_r = {1'b0, sn[26:16]} + {11'd0, rnd};
    er_r   = er + $signed({9'd0, mant_r[11]});
  end

  always_comb begin
    if (a_nan || b_nan || c_nan)                       r_o = QNAN;
    else if ((a_inf || b_inf) && (a_zero || b_zero))   r_o = QNAN;
    else if (a_inf || b_inf) begin
      if (c_inf && (c.sgn != sp))                      r_o = QNAN;
      else                                             r_o = {sp, 5'h1F, 10'd0};
    end
    else if (c_inf)                                    r_o = c_i;
    else if (a_zero || b_zero) begin
      if (c_zero)                                      r_o = {sp & c.sgn, 15'd0};
      else                                             r_o = c_i;
    end
    else if (s == 27'd0)                               r_o = 16'h0000;
    else if (er <= 10'sd0)                             r_o = {rsgn, 15'd0};
    else if (er_r >= 10'sd31)                          r_o = {rsgn, 5'h1F, 10'd0};
    else r_o = {rsgn, er_r[4:0], (mant_r[11] ? mant_r[10:1] : mant_r[9:0])};
  end
endmodule

// File: rtl/opa_walk.sv
module opa_walk #(
  parameter int DIM = 4,
  localparam int RW = (DIM > 1) ? $clog2(DIM) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  output logic          accept,
  output logic          busy,
  output logic          done,
  output logic [RW-1:0] row,
  output logic [RW-1:0] col
);
  localparam logic [RW-1:0] LAST = RW'(DIM - 1);

  assign accept = start & ~busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      done <= 1'b0;
      row  <= '0;
      col  <= '0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        busy <= 1'b1;
        row  <= '0;
        col  <= '0;
      end else if (busy) begin
        if (col == LAST) begin
          col <= '0;
          if (row == LAST) begin
            busy <= 1'b0;
            done <= 1'b1;
          end else begin
            row <= row + 1'b1;
          end
        end else begin
          col <= col + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/opa_tile.sv
module opa_tile #(
  parameter int DEPTH = 16,
  parameter int EW    = 16,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                we,
  input  logic [AW-1:0]       wa,
  input  logic [EW-1:0]       wd,
  output logic [EW-1:0]       cur,
  input  logic [AW-1:0]       ra,
  output logic [EW-1:0]       rd,
  output logic [DEPTH*EW-1:0] flat
);
  logic [EW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[wa] <= wd;
    end
  end

  always_ff @(posedge clk) rd <= mem[ra];

  assign cur = mem[wa];

  for (genvar g = 0; g < DEPTH; g++) begin : g_flat
    assign flat[g*EW +: EW] = mem[g];
  end
endmodule

// File: rtl/opa_engine.sv
module opa_engine
  import opa_pkg::*;
#(
  parameter int DIM = 4,
  localparam int VW    = DIM * EW,
  localparam int PB    = EW / 8,
  localparam int PW    = VW / 8,
  localparam int DEPTH = DIM * DIM,
  localparam int AW    = $clog2(DEPTH),
  localparam int RW    = (DIM > 1) ? $clog2(DIM) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          sub_mode,
  input  logic [VW-1:0] vec_a,
  input  logic [VW-1:0] vec_b,
  input  logic [PW-1:0] pred_a,
  input  logic [PW-1:0] pred_b,
  output logic          busy,
  output logic          done,
  input  logic [AW-1:0] rd_addr,
  output logic [EW-1:0] rd_data
);
  logic          accept, act, sub_q;
  logic [RW-1:0] row, col;
  logic [AW-1:0] idx;
  logic [VW-1:0] a_q, b_q;
  logic [DIM-1:0] pa_q, pb_q;
  logic [EW-1:0] a_el [DIM];
  logic [EW-1:0] b_el [DIM];
  logic [EW-1:0] old_v, new_v, op_a;
  logic [DEPTH*EW-1:0] tile_flat;
  logic unused_pred;

  assign unused_pred = ^{pred_a, pred_b};

  opa_walk #(.DIM(DIM)) u_walk (
    .clk(clk), .rst(rst), .start(start), .accept(accept),
    .busy(busy), .done(done), .row(row), .col(col)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q   <= '0;
      b_q   <= '0;
      sub_q <= 1'b0;
    end else if (accept) begin
      a_q   <= vec_a;
      b_q   <= vec_b;
      sub_q <= sub_mode;
    end
  end

  for (genvar g = 0; g < DIM; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst) begin
        pa_q[g] <= 1'b0;
        pb_q[g] <= 1'b0;
      end else if (accept) begin
        pa_q[g] <= pred_a[g*PB];
        pb_q[g] <= pred_b[g*PB];
      end
    end
    assign a_el[g] = a_q[g*EW +: EW];
    assign b_el[g] = b_q[g*EW +: EW];
  end

  assign idx  = AW'(row) * AW'(DIM) + AW'(col);
  assign act  = pa_q[row] & pb_q[col];
  assign op_a = a_el[row] ^ {sub_q, {(EW-1){1'b0}}};

  opa_fma16 u_fma (.a_i(op_a), .b_i(b_el[col]), .c_i(old_v), .r_o(new_v));

  opa_tile #(.DEPTH(DEPTH), .EW(EW)) u_tile (
    .clk(clk), .rst(rst), .we(busy & act), .wa(idx), .wd(new_v),
    .cur(old_v), .ra(rd_addr), .rd(rd_data), .flat(tile_flat)
  );
endmodule

// File: rtl/opa_engine_chk.sv
module opa_engine_chk #(
  parameter int DIM = 4,
  parameter int EW  = 16,
  localparam int RW = (DIM > 1) ? $clog2(DIM) : 1
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    start,
  input logic                    busy,
  input logic                    done,
  input logic                    act,
  input logic [RW-1:0]           row,
  input logic [RW-1:0]           col,
  input logic [DIM*DIM*EW-1:0]   tile_flat
);
  localparam logic [RW-1:0] LAST = RW'(DIM - 1);

  // R1: no tile change while idle
  a_r1_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !busy |=> $stable(tile_flat));

  // R2: busy only rises on a start
  a_r2_rise_on_start: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));

  // R2: done follows the last busy cycle and never overlaps busy
  a_r2_done_after_walk: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));

  // R3: row-major stepping
  a_r3_row_major: assert property (@(posedge clk) disable iff (rst)
    (busy && col != LAST) |=> (busy && row == $past(row) && col == RW'($past(col) + 1'b1)));

  // R4: inactive element leaves tile untouched
  a_r4_inactive_hold: assert property (@(posedge clk) disable iff (rst)
    (busy && !act) |=> $stable(tile_flat));

  // R7: start during a pass does not end or restart it
  a_r7_start_ignored: assert property (@(posedge clk) disable iff (rst)
    (busy && start && !(row == LAST && col == LAST)) |=> (busy && !done));
endmodule

bind opa_engine opa_engine_chk #(.DIM(DIM), .EW(EW)) u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
  .act(act), .row(row), .col(col), .tile_flat(tile_flat)
);

// File: tb/sim_opa_engine.sv
module sim_opa_engine;
  localparam int CLK_PERIOD = 10;
  localparam int DIM   = 4;
  localparam int DEPTH = DIM * DIM;
  localparam int VW    = DIM * 16;
  localparam int PW    = VW / 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0, sub_mode = 1'b0;
  logic [VW-1:0] vec_a = '0, vec_b = '0;
  logic [PW-1:0] pred_a = '0, pred_b = '0;
  logic busy, done;
  logic [3:0] rd_addr = '0;
  logic [15:0] rd_data;

  int total = 0, bad = 0;
  logic [15:0] model [DEPTH];

  always #(CLK_PERIOD/2) clk = ~clk;

  opa_engine #(.DIM(DIM)) u0 (
    .clk(clk), .rst(rst), .start(start), .sub_mode(sub_mode),
    .vec_a(vec_a), .vec_b(vec_b), .pred_a(pred_a), .pred_b(pred_b),
    .busy(busy), .done(done), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  function automatic logic [15:0] ref_fma(input logic [15:0] a, input logic [15:0] b,
                                          input logic [15:0] c);
    int ae = int'(a[14:10]);
    int be = int'(b[14:10]);
    int ce = int'(c[14:10]);
    bit an = (ae == 31) && (a[9:0] != 0);
    bit bn = (be == 31) && (b[9:0] != 0);
    bit cn = (ce == 31) && (c[9:0] != 0);
    bit ai = (ae == 31) && (a[9:0] == 0);
    bit bi = (be == 31) && (b[9:0] == 0);
    bit ci = (ce == 31) && (c[9:0] == 0);
    bit az = (ae == 0), bz = (be == 0), cz = (ce == 0);
    bit ps = a[15] ^ b[15];
    bit sg;
    logic [127:0] pv, cv, mag, rem, half;
    logic [11:0] m;
    int L, ex;
    if (an || bn || cn) return 16'h7E00;
    if ((ai || bi) && (az || bz)) return 16'h7E00;
    if (ai || bi) begin
      if (ci && (c[15] != ps)) return 16'h7E00;
      return {ps, 5'h1F, 10'h0};
    end
    if (ci) return c;
    if (az || bz) begin
      if (cz) return {ps & c[15], 15'h0};
      return c;
    end
    // exact values in units of 2^-48
    pv = (128'({1'b1, a[9:0]}) * 128'({1'b1, b[9:0]})) << (ae + be - 2);
    cv = cz ? 128'd0 : (128'({1'b1, c[9:0]}) << (ce + 23));
    if (ps == c[15] || cz) begin
      mag = cz ? pv : pv + cv;
      sg  = ps;
    end else if (pv >= cv) begin
      mag = pv - cv; sg = ps;
    end else begin
      mag = cv - pv; sg = c[15];
    end
    if (mag == 0) return 16'h0000;
    L = 0;
    for (int i = 0; i < 128; i++) if (mag[i]) L = i;
    ex = L - 33;
    if (ex <= 0) return {sg, 15'h0};
    m    = 12'(mag >> (L - 10));
    rem  = mag & ((128'd1 << (L - 10)) - 128'd1);
    half = 128'd1 << (L - 11);
    if (rem > half || (rem == half && m[0])) m = m + 12'd1;
    if (m == 12'd2048) begin m = 12'd1024; ex = ex + 1; end
    if (ex >= 31) return {sg, 5'h1F, 10'h0};
    return {sg, 5'(ex), m[9:0]};
  endfunction

  function automatic logic [15:0] rnd_fp();
    logic [4:0] e = 5'(8 + ($urandom % 14));
    return {1'($urandom), e, 10'($urandom)};
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; start = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < DEPTH; i++) model[i] = 16'h0000;
  endtask

  task automatic check_tile(input string tag);
    rd_addr = 4'd0;
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk);
      chk(rd_data == model[i], tag, $sformatf("elem %0d", i), 32'(rd_data), 32'(model[i]));
      rd_addr = 4'(i + 1);
    end
  endtask

  task automatic run_op(input logic [VW-1:0] va, input logic [VW-1:0] vb,
                        input logic [PW-1:0] pa, input logic [PW-1:0] pb,
                        input bit sub, input string tag, input int probe, input int reps);
    logic [15:0] nxt [DEPTH];
    logic [15:0] old [DEPTH];
    @(negedge clk);
    start = 1'b1; vec_a = va; vec_b = vb; pred_a = pa; pred_b = pb; sub_mode = sub;
    for (int rep = 0; rep < reps; rep++) begin
      for (int r = 0; r < DIM; r++)
        for (int c = 0; c < DIM; c++) begin
          int k = r * DIM + c;
          logic [15:0] aa = va[r*16 +: 16] ^ {sub, 15'h0};
          old[k] = model[k];
          if (pa[2*r] && pb[2*c]) nxt[k] = ref_fma(aa, vb[c*16 +: 16], model[k]);
          else                    nxt[k] = model[k];
        end
      for (int n = 1; n <= DEPTH; n++) begin
        @(negedge clk);
        if (n == 1) begin
          start = 1'b0;
          chk(busy == 1'b1, "R2", "busy after start", 32'(busy), 32'd1);
        end
        if (n == probe + 2)
          chk(rd_data == old[probe], "R12", $sformatf("read-before-write elem %0d", probe),
              32'(rd_data), 32'(old[probe]));
        if (n == probe + 1) rd_addr = 4'(probe);
        if (n == 3) begin
          start = 1'b1; vec_a = ~va; vec_b = ~vb; pred_a = '1; pred_b = '1; sub_mode = ~sub;
        end
        if (n == 4) start = 1'b0;
        if (n > 1 && n < DEPTH)
          chk(busy == 1'b1 && done == 1'b0, "R7", $sformatf("still busy cycle %0d", n),
              32'({busy, done}), 32'b10);
      end
      @(negedge clk);
      chk(busy == 1'b0 && done == 1'b1, "R2", "done pulse after last write",
          32'({busy, done}), 32'b01);
      for (int k = 0; k < DEPTH; k++) model[k] = nxt[k];
      if (rep < reps - 1) begin
        start = 1'b1; vec_a = va; vec_b = vb; pred_a = pa; pred_b = pb; sub_mode = sub;
      end
    end
    @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0, "R7", "no queued pass, done cleared",
        32'({busy, done}), 32'b00);
    check_tile(tag);
  endtask

  function automatic logic [VW-1:0] rnd_vec();
    logic [VW-1:0] v;
    for (int i = 0; i < DIM; i++) v[i*16 +: 16] = rnd_fp();
    return v;
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    total++; bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [VW-1:0] ones;
    void'($urandom(32'd20240611));
    for (int i = 0; i < DIM; i++) ones[i*16 +: 16] = 16'h3C00;
    do_reset();
    @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0, "R1", "idle after reset", 32'({busy, done}), 32'b00);
    check_tile("R1");

    // R3: load rows with A lanes, then add B lanes per column
    run_op(rnd_vec(), ones, '1, '1, 1'b0, "R3", 5, 1);
    run_op(ones, rnd_vec(), '1, '1, 1'b0, "R3", 10, 1);

    // R5 and R4: random predicates
    for (int t = 0; t < 12; t++)
      run_op(rnd_vec(), rnd_vec(), PW'($urandom), PW'($urandom), 1'b0, "R5", t % 15, 1);

    // R4: all inactive, and only odd predicate bits set
    run_op(rnd_vec(), rnd_vec(), '0, '1, 1'b0, "R4", 0, 1);
    run_op(rnd_vec(), rnd_vec(), 8'hAA, 8'hAA, 1'b0, "R4", 7, 1);

    // R6: subtract mode
    for (int t = 0; t < 4; t++)
      run_op(rnd_vec(), rnd_vec(), PW'($urandom), '1, 1'b1, "R6", 3 * t, 1);

    // R2: back-to-back passes with start in the done cycle
    run_op(rnd_vec(), rnd_vec(), '1, '1, 1'b0, "R2", 14, 3);

    // R10, R9, R8: overflow, NaN, inf*0, subnormal inputs
    run_op({16'h7C00, 16'h0200, 16'h7BFF, 16'hFE01},
           {16'h0000, 16'h7BFF, 16'h3C00, 16'hC000}, '1, '1, 1'b0, "R10", 2, 1);
    run_op({16'h7BFF, 16'h0001, 16'hFBFF, 16'h7C00},
           {16'h7BFF, 16'h3C00, 16'h7BFF, 16'hBC00}, '1, '1, 1'b0, "R9", 9, 1);

    // R8 and R11: fresh tile, flushed tiny products, signed zeros, cancellation
    do_reset();
    run_op({16'h9400, 16'h1400, 16'h9400, 16'h3C00},
           {16'h1400, 16'h1400, 16'h1400, 16'h3C00}, '1, '1, 1'b0, "R8", 4, 1);
    run_op({16'h8000, 16'h0000, 16'h8000, 16'h3C00},
           {16'h3C00, 16'h3C00, 16'h3C00, 16'h3C00}, '1, '1, 1'b0, "R11", 1, 1);
    run_op({16'h8000, 16'h0000, 16'h8000, 16'h3C00},
           {16'h3C00, 16'h3C00, 16'h3C00, 16'h3C00}, '1, '1, 1'b1, "R11", 12, 1);
    run_op({16'h0400, 16'h0401, 16'h0C00, 16'h3555},
           {16'h3800, 16'h37FF, 16'h8C00, 16'h3555}, '1, '1, 1'b0, "R8", 6, 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule